// File: doc/BRIEF.md
# Bus Idle Wait Timer for a Consumer-Electronics Control Transmitter

This block decides when a transmitter on a shared consumer-electronics control line may drive the start bit of a new frame. It measures how long the line has been continuously high (idle). It counts in half nominal data-bit periods, paced by an input tick. It grants the transmitter once a pending request has seen enough idle time.

The required idle time comes from a 3-bit setting. Codes 1 to 7 give a fixed wait. Code 0 picks the wait from what happened last on the bus:
- a short wait when this node's own last frame failed;
- a medium wait when some other node was the last initiator;
- a long wait when this node's own last frame ended well.

The outcome is kept in a small history register. It is fed by event pulses from the transmitter and by a pulse that reports a frame from another node.

Top module: `sft_timer`

## Requirements
- R1: After reset the idle count is 0 and the history is "new initiator", so with code 0 the grant stays low until 8 half-bit ticks of high line have been seen.
- R2: Any clock cycle with `line_hi` low clears the idle count to 0.
- R3: The idle count rises by one on each clock edge where `line_hi` and `half_tick` are both 1. It holds when `half_tick` is 0. It saturates at its maximum, 15 for the default 4-bit width, and never wraps, so a long idle period keeps the grant up.
- R4: For code c in 1..7, the threshold is 2c-1 half-bit ticks (1, 3, 5, 7, 9, 11, 13).
- R5: With code 0 and history "last initiator, failed", the threshold is 5 half-bit ticks.
- R6: With code 0 and history "new initiator", the threshold is 8 half-bit ticks. A `foreign_ev` pulse with no own-result event in the same cycle sets this history.
- R7: With code 0 and history "last initiator, succeeded", the threshold is 12 half-bit ticks. An `ok_ev` pulse with no failure event in the same cycle sets this history.
- R8: `grant` is 1 only while `tx_req` is 1. Dropping `tx_req` drops `grant` in the same cycle.
- R9: `grant` is 0 in any cycle where `line_hi` is 0.
- R10: When events coincide, a failure event wins over `ok_ev`, and both own-result events win over `foreign_ev`.
- R11: Each of the four failure-event bits alone marks the last transmission as failed:
  - bit 0: arbitration lost;
  - bit 1: transmit error;
  - bit 2: data underrun;
  - bit 3: missing acknowledge.
- R12: The threshold follows `sft_code` combinationally. A code change during an idle period takes effect in the same cycle against the count already reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_tick | input | 1 | One-cycle pulse per half nominal data-bit period |
| line_hi | input | 1 | Sampled bus level, 1 = idle/high |
| tx_req | input | 1 | Transmitter has a frame waiting |
| sft_code | input | 3 | Idle wait setting, 0 = automatic |
| fail_ev | input | 4 | Own transmission failed: arbitration lost, transmit error, underrun, missing acknowledge |
| ok_ev | input | 1 | Own transmission completed at end of message |
| foreign_ev | input | 1 | A frame from another initiator was seen |
| grant | output | 1 | Start bit may be driven now |

## Verification
The assertions assume that `half_tick`, the event pulses and `line_hi` are synchronous to `clk` and stable through each edge. They also assume the event pulses last one cycle, so the history is judged only in the cycle after an event. The stimulus changes every input only on the falling clock edge. It fires each event for exactly one cycle. It holds `tx_req` and `sft_code` steady across each idle run, except where a requirement calls for a change in the middle of the run. Ticks come both on every cycle and with idle cycles between them, so that the hold behaviour of the count is covered as well as its stepping.

// File: rtl/sft_pkg.sv
package sft_pkg;

  typedef enum logic [1:0] {
    HIST_NEW  = 2'd0,
    HIST_OK   = 2'd1,
    HIST_FAIL = 2'd2
  } hist_e;

  localparam int unsigned CODE_W = 3;

endpackage

// File: rtl/sft_idle_cnt.sv
module sft_idle_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_hi,
  input  logic             half_tick,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!line_hi) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (half_tick && (cnt_q != CNT_MAX)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/sft_history.sv
module sft_history
  import sft_pkg::*;
#(
  parameter int unsigned N_FAIL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_FAIL-1:0] fail_ev,
  input  logic              ok_ev,
  input  logic              foreign_ev,
  output hist_e             hist_o
);

  hist_e hist_q;
  hist_e hist_d;
  logic  hist_en;
  logic  any_fail;

  assign any_fail = |fail_ev;

  always_comb begin
    hist_en = 1'b1;
    hist_d  = hist_q;
    if (any_fail) begin
      hist_d = HIST_FAIL;
    end else if (ok_ev) begin
      hist_d = HIST_OK;
    end else if (foreign_ev) begin
      hist_d = HIST_NEW;
    end else begin
      hist_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= HIST_NEW;
    end else if (hist_en) begin
      hist_q <= hist_d;
    end
  end

  assign hist_o = hist_q;

endmodule

// File: rtl/sft_threshold.sv
module sft_threshold
  import sft_pkg::*;
#(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned TH_FAIL = 5,
  parameter int unsigned TH_NEW  = 8,
  parameter int unsigned TH_OK   = 12
) (
  input  logic [CODE_W-1:0] code_i,
  input  hist_e             hist_i,
  output logic [CNT_W-1:0]  thr_o
);

  localparam int unsigned N_CODES = 1 << CODE_W;

  logic [CNT_W-1:0] fixed_tbl [N_CODES];
  logic [CNT_W-1:0] auto_thr;

  assign fixed_tbl[0] = '0;
  for (genvar c = 1; c < N_CODES; c++) begin : g_code
    assign fixed_tbl[c] = CNT_W'(2 * c - 1);
  end

  always_comb begin
    unique case (hist_i)
      HIST_FAIL: auto_thr = CNT_W'(TH_FAIL);
      HIST_OK:   auto_thr = CNT_W'(TH_OK);
      default:   auto_thr = CNT_W'(TH_NEW);
    endcase
  end

  assign thr_o = (code_i == '0) ? auto_thr : fixed_tbl[code_i];

endmodule

// File: rtl/sft_timer.sv
module sft_timer
  import sft_pkg::*;
#(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned N_FAIL  = 4,
  parameter int unsigned TH_FAIL = 5,
  parameter int unsigned TH_NEW  = 8,
  parameter int unsigned TH_OK   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_tick,
  input  logic              line_hi,
  input  logic              tx_req,
  input  logic [2:0]        sft_code,
  input  logic [N_FAIL-1:0] fail_ev,
  input  logic              ok_ev,
  input  logic              foreign_ev,
  output logic              grant
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] thr;
  hist_e            hist_q;

  sft_idle_cnt #(.CNT_W(CNT_W)) idle_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_hi   (line_hi),
    .half_tick (half_tick),
    .cnt_o     (cnt_q)
  );

  sft_history #(.N_FAIL(N_FAIL)) hist_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fail_ev    (fail_ev),
    .ok_ev      (ok_ev),
    .foreign_ev (foreign_ev),
    .hist_o     (hist_q)
  );

  sft_threshold #(
    .CNT_W   (CNT_W),
    .TH_FAIL (TH_FAIL),
    .TH_NEW  (TH_NEW),
    .TH_OK   (TH_OK)
  ) thr_i (
    .code_i (sft_code),
    .hist_i (hist_q),
    .thr_o  (thr)
  );

  assign grant = tx_req && line_hi && (cnt_q >= thr);

endmodule

// File: rtl/sft_timer_chk.sv
module sft_timer_chk #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned N_FAIL = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              half_tick,
  input logic              line_hi,
  input logic              tx_req,
  input logic [N_FAIL-1:0] fail_ev,
  input logic              ok_ev,
  input logic              foreign_ev,
  input logic              grant,
  input logic [CNT_W-1:0]  idle_cnt,
  input logic [1:0]        hist
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  a_r2_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !line_hi |=> (idle_cnt == '0));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (line_hi && half_tick && idle_cnt != CMAX) |=>
      (idle_cnt == CNT_W'($past(idle_cnt) + 1'b1)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (line_hi && (!half_tick || idle_cnt == CMAX)) |=> $stable(idle_cnt));

  a_r8_no_req_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_req |-> !grant);

  a_r4_min_wait: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (idle_cnt != '0));

  a_r5_fail_hist: assert property (@(posedge clk) disable iff (!rst_n)
    (|fail_ev) |=> (hist == 2'd2));

  a_r7_ok_hist: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_ev && !(|fail_ev)) |=> (hist == 2'd1));

  a_r6_foreign_hist: assert property (@(posedge clk) disable iff (!rst_n)
    (foreign_ev && !ok_ev && !(|fail_ev)) |=> (hist == 2'd0));

endmodule

bind sft_timer sft_timer_chk #(.CNT_W(CNT_W), .N_FAIL(N_FAIL)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .half_tick  (half_tick),
  .line_hi    (line_hi),
  .tx_req     (tx_req),
  .fail_ev    (fail_ev),
  .ok_ev      (ok_ev),
  .foreign_ev (foreign_ev),
  .grant      (grant),
  .idle_cnt   (cnt_q),
  .hist       (hist_q)
);

// File: tb/sft_timer_tb_top.sv
module sft_timer_tb_top;

  logic       clk;
  logic       rst_n;
  logic       half_tick;
  logic       line_hi;
  logic       tx_req;
  logic [2:0] sft_code;
  logic [3:0] fail_ev;
  logic       ok_ev;
  logic       foreign_ev;
  logic       grant;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic  g;
    string tag;
  } item_t;
  item_t sb_q[$];

  // independent reference state: count and history (0 new,1 ok,2 fail)
  int m_cnt  = 0;
  int m_hist = 0;

  sft_timer dut_i (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .line_hi(line_hi),
    .tx_req(tx_req), .sft_code(sft_code), .fail_ev(fail_ev), .ok_ev(ok_ev),
    .foreign_ev(foreign_ev), .grant(grant)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int thr_of(input int code, input int hist);
    if (code != 0) return 2 * code - 1;
    if (hist == 2) return 5;
    if (hist == 1) return 12;
    return 8;
  endfunction

  task automatic step(input logic ln, input logic tk, input logic rq,
                      input int code, input logic [3:0] fe, input logic ok,
                      input logic fo, input string tag);
    item_t it;
    @(negedge clk);
    line_hi = ln; half_tick = tk; tx_req = rq; sft_code = 3'(code);
    fail_ev = fe; ok_ev = ok; foreign_ev = fo;
    it.g   = rq && ln && (m_cnt >= thr_of(code, m_hist));
    it.tag = tag;
    sb_q.push_back(it);
    if (!ln) m_cnt = 0;
    else if (tk && m_cnt < 15) m_cnt++;
    if (fe != 0) m_hist = 2;
    else if (ok) m_hist = 1;
    else if (fo) m_hist = 0;
  endtask

  task automatic idle(input int n, input int code, input logic rq, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, rq, code, 4'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic low(input int code, input string tag);
    step(1'b0, 1'b1, 1'b1, code, 4'h0, 1'b0, 1'b0, tag);
  endtask

  // monitor: pops one expected item per cycle after inputs settle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        total++;
        if (grant !== it.g) begin
          bad++;
          $display("FAIL %s grant actual=%0b expected=%0b", it.tag, grant, it.g);
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; half_tick = 0; line_hi = 1; tx_req = 0; sft_code = 0;
    fail_ev = 0; ok_ev = 0; foreign_ev = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state, request pending but no idle time yet
    step(1'b1, 1'b0, 1'b1, 0, 4'h0, 1'b0, 1'b0, "R1");
    idle(10, 0, 1'b1, "R1 R6");
    // R9 and R2: low line drops grant and clears count
    low(0, "R9");
    idle(3, 0, 1'b1, "R2");
    // R7: own success -> long wait
    step(1'b0, 1'b0, 1'b0, 0, 4'h0, 1'b1, 1'b0, "R7");
    idle(14, 0, 1'b1, "R7");
    // R5 / R11: each failure bit alone
    for (int b = 0; b < 4; b++) begin
      step(1'b0, 1'b0, 1'b0, 0, 4'(1 << b), 1'b0, 1'b0, "R11");
      idle(7, 0, 1'b1, "R5 R11");
      step(1'b0, 1'b0, 1'b0, 0, 4'h0, 1'b1, 1'b0, "R7");
    end
    // R10: failure beats success, success beats foreign
    step(1'b0, 1'b0, 1'b0, 0, 4'h1, 1'b1, 1'b1, "R10");
    idle(7, 0, 1'b1, "R10");
    step(1'b0, 1'b0, 1'b0, 0, 4'h0, 1'b1, 1'b1, "R10");
    idle(13, 0, 1'b1, "R10");
    // R6: foreign frame -> new initiator
    step(1'b0, 1'b0, 1'b0, 0, 4'h0, 1'b0, 1'b1, "R6");
    idle(10, 0, 1'b1, "R6");
    // R4: fixed codes
    for (int c = 1; c < 8; c++) begin
      low(c, "R4");
      idle(2 * c + 1, c, 1'b1, "R4");
    end
    // R8: request gating
    idle(2, 7, 1'b0, "R8");
    idle(2, 7, 1'b1, "R8");
    // R3: saturation and hold between ticks
    low(7, "R3");
    idle(20, 7, 1'b1, "R3");
    low(7, "R3");
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 1'b1, 1'b1, 7, 4'h0, 1'b0, 1'b0, "R3");
      step(1'b1, 1'b0, 1'b1, 7, 4'h0, 1'b0, 1'b0, "R3");
      step(1'b1, 1'b0, 1'b1, 7, 4'h0, 1'b0, 1'b0, "R3");
    end
    // R12: code change mid-idle
    low(7, "R12");
    idle(4, 7, 1'b1, "R12");
    idle(2, 2, 1'b1, "R12");
    idle(2, 6, 1'b1, "R12");

    @(negedge clk);
    @(negedge clk);
    #2;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule